// File: doc/BRIEF.md
# Circular Receive Buffer Packet Writer

This block sits between an upstream receive path, which has already decided which Ethernet frames to keep, and a byte-wide ring buffer in memory. It writes each kept frame into the ring behind a six-byte prefix. The prefix holds the address where the following frame will begin and a 32-bit status word that carries the byte count. The prefix is filled in only after the last data byte has been seen, so the final length is known. The block then moves a committed write pointer past the frame. That pointer is always rounded up to an even address.

Host software drains the ring by moving its read pointer and pulsing a decrement strobe for every frame it consumes. The block keeps a saturating pending-frame count and a sticky buffer-overflow flag. It combines both with three enable masks into one interrupt line. Frames that end with a bad indication leave no trace. A frame that would overrun the space the host has not yet read is abandoned and sets the overflow flag.

Top module: `rxring_writer`

## Requirements
- R1: The six prefix bytes, at ring offsets 0 to 5 from the frame start, are: next-frame address bits [7:0], next-frame address bits [15:8] (zero-extended), status byte 0, status byte 1, status byte 2, status byte 3. The status word holds the data byte count in bits [15:0], bit 16 set to 1 for a kept frame, and all other bits 0.
- R2: Data bytes are written in arrival order starting at ring offset 6 from the frame start. Every address wraps from `buf_end` back to `buf_start`, and no write falls outside `buf_start`..`buf_end`.
- R3: The next-frame address is the ring address after the last data byte, advanced by one more ring position when that address is odd. Every frame therefore starts on an even address, given an even `buf_start` and an odd `buf_end`.
- R4: `wr_ptr` changes only in the cycle that completes the prefix of a good frame, and takes the next-frame address. In that same cycle `pkt_count` increments.
- R5: A frame whose last byte carries `in_good`=0 changes neither `wr_ptr`, `pkt_count` nor `err_flag`.
- R6: Free space is computed in ring order from `wr_ptr` to `host_rdptr`, minus one byte, so equal pointers mean size-1 bytes free. When a byte would bring the data count plus 7 above the free space, the frame is abandoned: the rest of its bytes are ignored, `err_flag` is set, and `wr_ptr` and `pkt_count` keep their values.
- R7: While `rx_en` is 0, no new frame starts, no data byte is written, and `wr_ptr` follows `buf_start` one cycle later.
- R8: `pkt_count` saturates at 255 and decreases by one on `cnt_dec` when nonzero. A commit and a `cnt_dec` in the same cycle leave it unchanged. `pkt_flag` is 1 exactly when `pkt_count` is nonzero.
- R9: `irq` = `glob_ie` AND ((`pkt_flag` AND `pkt_ie`) OR (`err_flag` AND `err_ie`)).
- R10: `err_flag` stays set until `err_clr`. A drop in the same cycle as `err_clr` leaves it set.
- R11: Writing the prefix takes the six cycles after a good frame's last byte. Input bytes arriving in those cycles are ignored, so frames need at least six idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_good | input | 1 | With `in_eof`: frame is to be kept |
| in_data | input | 8 | Input byte |
| buf_start | input | AW | First ring address (even) |
| buf_end | input | AW | Last ring address (odd) |
| host_rdptr | input | AW | Host read pointer |
| cnt_dec | input | 1 | Decrement pending-frame count |
| pkt_ie | input | 1 | Frame-received interrupt enable |
| err_ie | input | 1 | Overflow interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| err_clr | input | 1 | Clear overflow flag |
| mem_we | output | 1 | Ring memory write strobe |
| mem_addr | output | AW | Ring memory write address |
| mem_wdata | output | 8 | Ring memory write data |
| wr_ptr | output | AW | Committed write pointer |
| pkt_count | output | CW | Pending-frame count |
| pkt_flag | output | 1 | Pending count is nonzero |
| err_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check the following. Each write falls inside the ring. The committed pointer holds still except on a commit and lands on an even address after one. The count steps by one on a commit and sticks at its ceiling. No data write happens with reception off. The overflow flag is sticky, and no interrupt is raised without the global enable.

Only the bench scenarios can show the rest. These are the exact bytes of the prefix and the data across many wrap positions, and the drop threshold at its boundary for several read-pointer distances. They also cover the silence after bad frames, frames ignored during the prefix window, the same-cycle commit-and-decrement case, and the full interrupt mask truth table.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_SKIP = 2'd2,
    ST_HDR  = 2'd3
  } rxw_state_e;

  localparam int HDR_BYTES = 6;
  localparam int IDX_W     = 3;
  localparam int LEN_W     = 16;
  localparam int SLACK     = HDR_BYTES + 1;  // prefix plus worst-case pad
endpackage

// File: rtl/rxw_space.sv
module rxw_space #(
  parameter int AW = 13
) (
  input  logic [AW-1:0] buf_start,
  input  logic [AW-1:0] buf_end,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_ptr,
  output logic [AW:0]   free_bytes
);
  localparam int SW = AW + 1;

  logic [SW-1:0] ring_size;
  logic [SW-1:0] used;

  always_comb begin
    ring_size = {1'b0, buf_end} - {1'b0, buf_start} + SW'(1);
    if (rd_ptr > wr_ptr) begin
      used       = '0;
      free_bytes = {1'b0, rd_ptr} - {1'b0, wr_ptr} - SW'(1);
    end else begin
      used       = {1'b0, wr_ptr} - {1'b0, rd_ptr};
      free_bytes = ring_size - used - SW'(1);
    end
  end
endmodule

// File: rtl/rxw_events.sv
module rxw_events #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          cnt_dec,
  input  logic          drop,
  input  logic          err_clr,
  input  logic          pkt_ie,
  input  logic          err_ie,
  input  logic          glob_ie,
  output logic [CW-1:0] pkt_count,
  output logic          pkt_flag,
  output logic          err_flag,
  output logic          irq
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (commit && !cnt_dec) begin
      cnt_en = (cnt_q != CNT_MAX);
      cnt_d  = cnt_q + CW'(1);
    end else if (cnt_dec && !commit) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = cnt_q - CW'(1);
    end
    err_d = drop ? 1'b1 : (err_clr ? 1'b0 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign pkt_count = cnt_q;
  assign pkt_flag  = (cnt_q != '0);
  assign err_flag  = err_q;
  assign irq       = glob_ie & ((pkt_flag & pkt_ie) | (err_q & err_ie));
endmodule

// File: rtl/rxw_framer.sv
module rxw_framer
  import rxw_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_good,
  input  logic [7:0]    in_data,
  input  logic [AW-1:0] buf_start,
  input  logic [AW-1:0] buf_end,
  input  logic [AW:0]   free_bytes,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] wr_ptr,
  output logic          commit,
  output logic          drop,
  output logic          hdr_busy
);
  localparam int SW = AW + 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES - 1);

  function automatic logic [AW-1:0] ring_add(input logic [AW-1:0] a,
                                             input logic [AW-1:0] k,
                                             input logic [AW-1:0] lo,
                                             input logic [AW-1:0] hi);
    logic [SW-1:0] s;
    logic [SW-1:0] sz;
    sz = {1'b0, hi} - {1'b0, lo} + SW'(1);
    s  = {1'b0, a} + {1'b0, k};
    if (s > {1'b0, hi}) s = s - sz;
    return s[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] even_up(input logic [AW-1:0] a,
                                            input logic [AW-1:0] lo,
                                            input logic [AW-1:0] hi);
    if (a[0]) return ring_add(a, AW'(1), lo, hi);
    return a;
  endfunction

  rxw_state_e       st_q, st_d;
  logic [AW-1:0]    cur_q, cur_d;      // tentative data address
  logic [AW-1:0]    base_q, base_d;    // saved frame start
  logic [AW-1:0]    nxt_q, nxt_d;      // next-frame address
  logic [AW-1:0]    wp_q, wp_d;        // committed pointer
  logic [LEN_W-1:0] len_q, len_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  logic [LEN_W-1:0] cand_len;
  logic [LEN_W:0]   need;
  logic             fits;
  logic [AW-1:0]    first_addr;
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    after_wr;
  logic [15:0]      nxt16;

  always_comb begin
    first_addr = ring_add(wp_q, AW'(HDR_BYTES), buf_start, buf_end);
    wr_addr    = (st_q == ST_IDLE) ? first_addr : cur_q;
    after_wr   = ring_add(wr_addr, AW'(1), buf_start, buf_end);
    cand_len   = (st_q == ST_IDLE) ? LEN_W'(1) : len_q + LEN_W'(1);
    need       = {1'b0, cand_len} + (LEN_W+1)'(SLACK);
    fits       = (need <= (LEN_W+1)'(free_bytes));
    nxt16      = 16'(nxt_q);
  end

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    base_d    = base_q;
    nxt_d     = nxt_q;
    wp_d      = wp_q;
    len_d     = len_q;
    idx_d     = idx_q;
    mem_we    = 1'b0;
    mem_addr  = wr_addr;
    mem_wdata = in_data;
    commit    = 1'b0;
    drop      = 1'b0;

    case (st_q)
      ST_IDLE, ST_DATA: begin
        if (!rx_en) begin
          st_d = ST_IDLE;
          if (st_q == ST_IDLE) wp_d = buf_start;
        end else if (in_valid && (st_q == ST_DATA || in_sof)) begin
          if (!fits) begin
            drop = 1'b1;
            st_d = in_eof ? ST_IDLE : ST_SKIP;
          end else begin
            mem_we = 1'b1;
            cur_d  = after_wr;
            len_d  = cand_len;
            if (st_q == ST_IDLE) base_d = wp_q;
            if (!in_eof) begin
              st_d = ST_DATA;
            end else if (in_good) begin
              st_d  = ST_HDR;
              idx_d = '0;
              nxt_d = even_up(after_wr, buf_start, buf_end);
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
      end

      ST_SKIP: begin
        if (!rx_en || (in_valid && in_eof)) st_d = ST_IDLE;
      end

      ST_HDR: begin
        mem_we   = 1'b1;
        mem_addr = ring_add(base_q, AW'(idx_q), buf_start, buf_end);
        case (idx_q)
          3'd0:    mem_wdata = nxt16[7:0];
          3'd1:    mem_wdata = nxt16[15:8];
          3'd2:    mem_wdata = len_q[7:0];
          3'd3:    mem_wdata = len_q[15:8];
          3'd4:    mem_wdata = 8'h01;
          default: mem_wdata = 8'h00;
        endcase
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == IDX_LAST) begin
          commit = 1'b1;
          wp_d   = nxt_q;
          st_d   = ST_IDLE;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      base_q <= '0;
      nxt_q  <= '0;
      wp_q   <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      base_q <= base_d;
      nxt_q  <= nxt_d;
      wp_q   <= wp_d;
      len_q  <= len_d;
      idx_q  <= idx_d;
    end
  end

  assign wr_ptr   = wp_q;
  assign hdr_busy = (st_q == ST_HDR);
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
  parameter int AW = 13,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_good,
  input  logic [7:0]    in_data,
  input  logic [AW-1:0] buf_start,
  input  logic [AW-1:0] buf_end,
  input  logic [AW-1:0] host_rdptr,
  input  logic          cnt_dec,
  input  logic          pkt_ie,
  input  logic          err_ie,
  input  logic          glob_ie,
  input  logic          err_clr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [AW-1:0] wr_ptr,
  output logic [CW-1:0] pkt_count,
  output logic          pkt_flag,
  output logic          err_flag,
  output logic          irq
);
  logic [AW:0] free_w;
  logic        commit_w;
  logic        drop_w;
  logic        hdr_busy_w;

  rxw_space #(.AW(AW)) u_space (
    .buf_start  (buf_start),
    .buf_end    (buf_end),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (host_rdptr),
    .free_bytes (free_w)
  );

  rxw_framer #(.AW(AW)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .in_good    (in_good),
    .in_data    (in_data),
    .buf_start  (buf_start),
    .buf_end    (buf_end),
    .free_bytes (free_w),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .wr_ptr     (wr_ptr),
    .commit     (commit_w),
    .drop       (drop_w),
    .hdr_busy   (hdr_busy_w)
  );

  rxw_events #(.CW(CW)) u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit_w),
    .cnt_dec   (cnt_dec),
    .drop      (drop_w),
    .err_clr   (err_clr),
    .pkt_ie    (pkt_ie),
    .err_ie    (err_ie),
    .glob_ie   (glob_ie),
    .pkt_count (pkt_count),
    .pkt_flag  (pkt_flag),
    .err_flag  (err_flag),
    .irq       (irq)
  );
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
  parameter int AW = 13,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic [AW-1:0] buf_start,
  input logic [AW-1:0] buf_end,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] wr_ptr,
  input logic [CW-1:0] pkt_count,
  input logic          cnt_dec,
  input logic          err_flag,
  input logic          err_clr,
  input logic          glob_ie,
  input logic          irq,
  input logic          commit,
  input logic          drop,
  input logic          hdr_busy
);
  localparam logic [CW-1:0] CMAX = '1;

  // R2: every write lands inside the ring
  p_addr_in_ring_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= buf_start && mem_addr <= buf_end));

  // R3: a commit leaves the pointer on an even address
  p_even_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !wr_ptr[0]);

  // R4: pointer moves only on a commit while enabled
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !commit) |=> $stable(wr_ptr));

  // R4: count rises by one on a lone commit below the ceiling
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cnt_dec && pkt_count != CMAX) |=> pkt_count == CW'($past(pkt_count) + 1'b1));

  // R6: a drop raises the overflow flag
  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> err_flag);

  // R7: no data byte is written with reception off
  p_no_write_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !hdr_busy) |-> rx_en);

  // R8: saturated count holds without a decrement
  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count == CMAX && !cnt_dec) |=> pkt_count == CMAX);

  // R9: no interrupt without the global enable
  p_irq_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_ie |-> !irq);

  // R10: overflow flag is sticky until cleared
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
endmodule

bind rxring_writer rxw_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .buf_start (buf_start),
  .buf_end   (buf_end),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .wr_ptr    (wr_ptr),
  .pkt_count (pkt_count),
  .cnt_dec   (cnt_dec),
  .err_flag  (err_flag),
  .err_clr   (err_clr),
  .glob_ie   (glob_ie),
  .irq       (irq),
  .commit    (commit_w),
  .drop      (drop_w),
  .hdr_busy  (hdr_busy_w)
);

// File: tb/rxring_writer_tb.sv
module rxring_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int CW   = 8;
  localparam int RS   = 'h10;
  localparam int RE   = 'h4F;
  localparam int SIZE = RE - RS + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0;
  logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_good = 1'b0;
  logic [7:0]    in_data = '0;
  logic [AW-1:0] buf_start = AW'(RS);
  logic [AW-1:0] buf_end = AW'(RE);
  logic [AW-1:0] host_rdptr = AW'(RS);
  logic          cnt_dec = 1'b0, pkt_ie = 1'b0, err_ie = 1'b0, glob_ie = 1'b0, err_clr = 1'b0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [AW-1:0] wr_ptr;
  logic [CW-1:0] pkt_count;
  logic          pkt_flag, err_flag, irq;

  int total = 0;
  int bad   = 0;
  int wcount = 0;
  int exp_cnt = 0;
  bit done = 1'b0;
  logic [7:0] mem [256];

  rxring_writer #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_good(in_good), .in_data(in_data), .buf_start(buf_start),
    .buf_end(buf_end), .host_rdptr(host_rdptr), .cnt_dec(cnt_dec), .pkt_ie(pkt_ie),
    .err_ie(err_ie), .glob_ie(glob_ie), .err_clr(err_clr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr), .pkt_count(pkt_count),
    .pkt_flag(pkt_flag), .err_flag(err_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wcount <= wcount + 1;
    end
  end

  function automatic int wrap(input int a);
    return ((a - RS) % SIZE + SIZE) % SIZE + RS;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 37 + i * 5 + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input bit good, input int seed, input bit dec_at_commit);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_good = good; in_data = pat(seed, i);
    end
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      cnt_dec = dec_at_commit && (j == 6);
    end
    cnt_dec = 1'b0;
  endtask

  task automatic pulse_dec();
    @(negedge clk); cnt_dec = 1'b1;
    @(negedge clk); cnt_dec = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  // Good frame into an empty ring; checks prefix, data, pointer and count.
  task automatic run_good(input int len, input int seed, input bit full);
    int st, nxt, w0, mism_h, mism_d;
    logic [7:0] hx [6];
    @(negedge clk);
    st = int'(wr_ptr);
    host_rdptr = wr_ptr;
    w0 = wcount;
    send_frame(len, 1'b1, seed, 1'b0);
    nxt = wrap(st + 6 + len);
    if (nxt % 2 == 1) nxt = wrap(nxt + 1);
    if (exp_cnt < 255) exp_cnt++;
    check(int'(wr_ptr) == nxt, "R3 next start", int'(wr_ptr), nxt);
    check(int'(pkt_count) == exp_cnt, "R4 count", int'(pkt_count), exp_cnt);
    if (full) begin
      hx[0] = 8'(nxt); hx[1] = 8'(nxt >> 8); hx[2] = 8'(len); hx[3] = 8'(len >> 8);
      hx[4] = 8'h01; hx[5] = 8'h00;
      mism_h = -1;
      for (int k = 0; k < 6; k++)
        if (mem[wrap(st + k)] !== hx[k] && mism_h < 0) mism_h = k;
      check(mism_h < 0, "R1 prefix byte", mism_h, -1);
      mism_d = -1;
      for (int i = 0; i < len; i++)
        if (mem[wrap(st + 6 + i)] !== pat(seed, i) && mism_d < 0) mism_d = i;
      check(mism_d < 0, "R2 data byte", mism_d, -1);
      check(wcount - w0 == len + 6, "R2 write count", wcount - w0, len + 6);
      check(pkt_flag == 1'b1, "R8 flag set", int'(pkt_flag), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0, p0, c0, off, maxlen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state
    check(pkt_count == 0, "R8 reset count", int'(pkt_count), 0);
    check(pkt_flag == 0, "R8 reset flag", int'(pkt_flag), 0);
    check(err_flag == 0, "R10 reset err", int'(err_flag), 0);
    check(irq == 0, "R9 reset irq", int'(irq), 0);
    check(int'(wr_ptr) == RS, "R7 ptr follows start", int'(wr_ptr), RS);

    // R7: disabled reception ignores a frame; pointer follows buf_start
    w0 = wcount;
    send_frame(10, 1'b1, 99, 1'b0);
    check(wcount == w0, "R7 no writes", wcount - w0, 0);
    check(pkt_count == 0, "R7 no count", int'(pkt_count), 0);
    buf_start = AW'('h20);
    @(negedge clk);
    check(int'(wr_ptr) == 'h20, "R7 ptr tracks", int'(wr_ptr), 'h20);
    buf_start = AW'(RS);
    @(negedge clk);
    check(int'(wr_ptr) == RS, "R7 ptr restore", int'(wr_ptr), RS);

    rx_en = 1'b1;
    // R1 R2 R3 R4: sweep of lengths; wraps the 64-byte ring many times
    for (int len = 1; len <= 40; len++) run_good(len, len, 1'b1);

    // R8: drain count and see the flag fall
    for (int i = 0; i < 40; i++) pulse_dec();
    exp_cnt = 0;
    @(negedge clk);
    check(pkt_count == 0, "R8 drained", int'(pkt_count), 0);
    check(pkt_flag == 0, "R8 flag clear", int'(pkt_flag), 0);

    // R5: bad frames leave no trace
    for (int len = 1; len <= 5; len++) begin
      @(negedge clk);
      host_rdptr = wr_ptr;
      p0 = int'(wr_ptr);
      send_frame(len, 1'b0, 50 + len, 1'b0);
      check(int'(wr_ptr) == p0, "R5 ptr", int'(wr_ptr), p0);
      check(pkt_count == 0, "R5 count", int'(pkt_count), 0);
      check(err_flag == 0, "R5 err", int'(err_flag), 0);
    end

    // R6: drop boundary for several read-pointer distances
    for (int t = 0; t < 3; t++) begin
      off = (t == 0) ? 10 : (t == 1) ? 27 : 64;
      maxlen = off - 8;
      @(negedge clk);
      host_rdptr = AW'(wrap(int'(wr_ptr) + off));
      p0 = int'(wr_ptr);
      send_frame(maxlen, 1'b1, 70 + t, 1'b0);
      exp_cnt++;
      check(int'(wr_ptr) != p0, "R6 fit accepted", int'(wr_ptr), p0);
      check(int'(pkt_count) == exp_cnt, "R6 fit count", int'(pkt_count), exp_cnt);
      check(err_flag == 0, "R6 fit no err", int'(err_flag), 0);
      @(negedge clk);
      host_rdptr = AW'(wrap(int'(wr_ptr) + off));
      p0 = int'(wr_ptr);
      send_frame(maxlen + 1, 1'b1, 80 + t, 1'b0);
      check(int'(wr_ptr) == p0, "R6 drop ptr", int'(wr_ptr), p0);
      check(int'(pkt_count) == exp_cnt, "R6 drop count", int'(pkt_count), exp_cnt);
      check(err_flag == 1, "R6 drop err", int'(err_flag), 1);
      pulse_clr();
      @(negedge clk);
      check(err_flag == 0, "R10 cleared", int'(err_flag), 0);
    end

    // R9: mask truth table with both flags set
    @(negedge clk);
    host_rdptr = AW'(wrap(int'(wr_ptr) + 4));
    send_frame(1, 1'b1, 90, 1'b0);
    check(err_flag == 1, "R6 tiny space drop", int'(err_flag), 1);
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      glob_ie = m[2]; pkt_ie = m[1]; err_ie = m[0];
      #1;
      check(irq == (m[2] & (m[1] | m[0])), "R9 both flags", int'(irq), int'(m[2] & (m[1] | m[0])));
    end
    pulse_clr();
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      glob_ie = m[2]; pkt_ie = m[1]; err_ie = m[0];
      #1;
      check(irq == (m[2] & m[1]), "R9 pkt only", int'(irq), int'(m[2] & m[1]));
    end
    glob_ie = 1'b0; pkt_ie = 1'b0; err_ie = 1'b0;

    // R10: drop and clear in the same cycle keeps the flag set
    @(negedge clk);
    host_rdptr = AW'(wrap(int'(wr_ptr) + 4));
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_good = 1'b1; err_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; err_clr = 1'b0;
    check(err_flag == 1, "R10 set wins", int'(err_flag), 1);
    pulse_clr();

    // R11: a frame arriving during prefix writing is ignored
    @(negedge clk);
    host_rdptr = wr_ptr;
    p0 = int'(wr_ptr);
    w0 = wcount;
    c0 = exp_cnt;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == 7); in_good = 1'b1; in_data = pat(5, i);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == 2); in_good = 1'b1; in_data = 8'hEE;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (10) @(negedge clk);
    exp_cnt = c0 + 1;
    check(wcount - w0 == 14, "R11 writes", wcount - w0, 14);
    check(int'(pkt_count) == exp_cnt, "R11 count", int'(pkt_count), exp_cnt);
    check(int'(wr_ptr) == wrap(p0 + 14), "R11 ptr", int'(wr_ptr), wrap(p0 + 14));

    // R8: commit and decrement together leave the count unchanged
    @(negedge clk);
    host_rdptr = wr_ptr;
    send_frame(3, 1'b1, 6, 1'b1);
    check(int'(pkt_count) == exp_cnt, "R8 simultaneous", int'(pkt_count), exp_cnt);

    // R8: saturation at 255
    for (int f = 0; f < 260; f++) run_good(1, f, 1'b0);
    check(pkt_count == 8'hFF, "R8 saturated", int'(pkt_count), 255);
    pulse_dec();
    @(negedge clk);
    check(pkt_count == 8'hFE, "R8 dec from top", int'(pkt_count), 254);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule